// File: doc/BRIEF.md
# EEPROM Self-Timed Programming Engine

This block sits behind the serial front end of a three-wire EEPROM. The front end decodes each instruction and hands over an operation code, a word address and a data word. The engine then decides whether the operation may run and starts it at the right moment. It times the operation with clock-cycle counters that stand in for the millisecond programming times, and it updates the word array. Reads are served straight from the array through a plain read port.

Programming is guarded by an enable latch. The latch comes out of power-on reset disabled and is also cleared whenever the power-good input drops. A programming request is only armed while the latch is set. The armed request starts when chip select falls, and from then on it needs no further clock edges from the host. A word write, and a fill of the whole array, each run an erase pass first and then the program pass.

The host can poll progress. After starting an operation it holds chip select low for at least the minimum low time, then raises it. The data-out pin then drives the busy state (0) or the ready state (1) until chip select falls again.

The request interface is valid/ready. `req_ready` is low for the whole of a programming cycle. A request offered while `req_ready` is low is dropped, not stored, so the front end must treat it as rejected. There is no other back-pressure.

Top module: `eeprog_engine`

## Requirements
- R1: After reset the enable latch is clear, `busy` is 0, `dout_oe` is 0, `req_ready` is 1, and every array word reads 0.
- R2: Operation codes on `req_op` are: 1 enable writes, 2 disable writes, 3 word erase, 4 word write, 5 erase all, 6 write all; other codes do nothing. Codes 3 to 6 have no effect on `busy` or the array while the enable latch is clear. Code 1 sets the latch and code 2 clears it.
- R3: An armed programming operation starts only on a falling edge of `cs`. `busy` rises in the cycle after the edge is sampled. While `cs` stays high, the operation stays armed and does not start.
- R4: A word erase sets every bit of the addressed word to 1, with `busy` high for exactly T_WORD_CYC cycles.
- R5: A word write keeps `busy` high for T_WORD_CYC cycles. During the first half the word keeps its old value; during the second half it reads all ones. When `busy` falls the word holds the new data.
- R6: Erase all sets every word to all ones, with `busy` high for 2*T_WORD_CYC cycles.
- R7: Write all keeps `busy` high for 4*T_WORD_CYC cycles. During the first half the words keep their old values; during the second half they read all ones. When `busy` falls every word holds the given data.
- R8: The array changes in the same cycle that `busy` falls. While `busy` is high in its last cycle, the target still shows its previous contents.
- R9: `req_ready` is 0 while `busy` is 1. Requests offered then are discarded: they change neither the latch nor the array, and they arm nothing.
- R10: If `cs` rises while `busy` is 1 after at least CSL_MIN_CYC sampled low cycles, `dout_oe` goes to 1 in the next cycle. `dout` then shows 0 while busy and 1 once done. `dout_oe` goes to 0 as soon as `cs` goes low.
- R11: `dout_oe` stays 0 after a low pulse of `cs` shorter than CSL_MIN_CYC cycles. It also stays 0 when `cs` is held low for the whole cycle and raised only afterwards.
- R12: While `pwr_good` is 0 the enable latch is cleared and enable-write requests are ignored. A running cycle is aborted: `busy` is 0 in the next cycle and no further array update is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| pwr_good | input | 1 | Supply above the programming threshold |
| cs | input | 1 | Chip select, synchronous to clk |
| req_valid | input | 1 | Decoded request present |
| req_ready | output | 1 | Engine can take a request (low while busy) |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | ADDR_W | Word address of the request |
| req_data | input | DATA_W | Data word of the request |
| rd_addr | input | ADDR_W | Read port address |
| rd_data | output | DATA_W | Array word at rd_addr |
| busy | output | 1 | Self-timed cycle in progress |
| dout | output | 1 | Status value: 0 busy, 1 ready |
| dout_oe | output | 1 | Drive enable for the status value |

## Verification
The bench targets the two-phase operations. It reads the target word early in a write or write-all, late in it, and at the cycle `busy` falls. A design that skipped the erase pass, or updated the array one cycle late, would show the wrong word at one of those points. The bench also checks the status window at exactly the minimum low time and one cycle short of it, and with `cs` held low through the whole cycle. A wrong threshold or a stale status enable would drive `dout` when it should not. Finally, it drops power-good mid-cycle and offers requests while busy: a design that let either one through would leave the latch set or change the array.

// File: rtl/eeprog_pkg.sv
package eeprog_pkg;
  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_WREN  = 3'd1,
    OP_WRDIS = 3'd2,
    OP_ERASE = 3'd3,
    OP_WRITE = 3'd4,
    OP_ERALL = 3'd5,
    OP_WRALL = 3'd6
  } op_e;

  function automatic logic is_prog(op_e o);
    return (o == OP_ERASE) || (o == OP_WRITE) || (o == OP_ERALL) || (o == OP_WRALL);
  endfunction
endpackage

// File: rtl/eeprog_latch.sv
module eeprog_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic set_i,
  input  logic clr_i,
  output logic en_o
);
  // Power loss and the disable request win over the enable request.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  en_o <= 1'b0;
    else if (!pwr_good || clr_i) en_o <= 1'b0;
    else if (set_i)              en_o <= 1'b1;
  end
endmodule

// File: rtl/eeprog_status.sv
module eeprog_status #(
  parameter int CSL_MIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic busy,
  output logic cs_fall,
  output logic dout,
  output logic dout_oe
);
  localparam int CW = $clog2(CSL_MIN + 1);

  logic          cs_q;
  logic [CW-1:0] low_cnt;
  logic          stat_en;

  assign cs_fall = cs_q && !cs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b0;
      low_cnt <= '0;
      stat_en <= 1'b0;
    end else begin
      cs_q <= cs;
      // Saturating count of sampled low cycles.
      if (cs)                          low_cnt <= '0;
      else if (low_cnt != CW'(CSL_MIN)) low_cnt <= low_cnt + 1'b1;
      // Status window opens on a qualified rise during a cycle.
      if (!cs)                                                stat_en <= 1'b0;
      else if (!cs_q && (low_cnt >= CW'(CSL_MIN)) && busy)   stat_en <= 1'b1;
    end
  end

  assign dout_oe = stat_en && cs;
  assign dout    = !busy;
endmodule

// File: rtl/eeprog_array.sv
module eeprog_array #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              all,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) words[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < DEPTH; i++)
        if (all || (waddr == ADDR_W'(i))) words[i] <= wdata;
    end
  end

  assign rdata = words[raddr];
endmodule

// File: rtl/eeprog_seq.sv
module eeprog_seq
  import eeprog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int T_WORD = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              wr_ok,
  input  logic              acc,
  input  op_e               op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic              cs_fall,
  output logic              busy,
  output logic              mem_we,
  output logic              mem_all,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int T_ALL   = 2 * T_WORD;
  localparam int T_WALL  = 4 * T_WORD;
  localparam int CNT_W   = $clog2(T_WALL);
  localparam int WR_TAIL = T_WORD / 2;   // cycles left after the word erase pass
  localparam int WA_TAIL = T_ALL;        // cycles left after the array erase pass

  logic              pend_v;
  op_e               pend_op, act_op;
  logic [ADDR_W-1:0] pend_addr, act_addr;
  logic [DATA_W-1:0] pend_data, act_data;
  logic [CNT_W-1:0]  cnt;

  function automatic logic [CNT_W-1:0] last_of(op_e o);
    case (o)
      OP_ERALL: return CNT_W'(T_ALL - 1);
      OP_WRALL: return CNT_W'(T_WALL - 1);
      default:  return CNT_W'(T_WORD - 1);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_op   <= OP_NONE;
      pend_addr <= '0;
      pend_data <= '0;
      act_op    <= OP_NONE;
      act_addr  <= '0;
      act_data  <= '0;
      cnt       <= '0;
      busy      <= 1'b0;
    end else if (!pwr_good) begin
      busy   <= 1'b0;
      pend_v <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (cs_fall) begin
      pend_v <= 1'b0;
      if (pend_v && wr_ok) begin
        busy     <= 1'b1;
        act_op   <= pend_op;
        act_addr <= pend_addr;
        act_data <= pend_data;
        cnt      <= last_of(pend_op);
      end
    end else if (acc && is_prog(op) && wr_ok) begin
      pend_v    <= 1'b1;
      pend_op   <= op;
      pend_addr <= addr;
      pend_data <= data;
    end
  end

  logic             erase_first, at_end, at_mid;
  logic [CNT_W-1:0] tail;

  assign erase_first = (act_op == OP_WRITE) || (act_op == OP_WRALL);
  assign tail        = (act_op == OP_WRALL) ? CNT_W'(WA_TAIL) : CNT_W'(WR_TAIL);
  assign at_end      = busy && pwr_good && (cnt == '0);
  assign at_mid      = busy && pwr_good && erase_first && (cnt == tail);

  assign mem_we    = at_end || at_mid;
  assign mem_all   = (act_op == OP_ERALL) || (act_op == OP_WRALL);
  assign mem_addr  = act_addr;
  assign mem_wdata = (at_end && erase_first) ? act_data : '1;
endmodule

// File: rtl/eeprog_engine.sv
module eeprog_engine
  import eeprog_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int T_WORD_CYC  = 16,
  parameter int CSL_MIN_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              cs,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              dout,
  output logic              dout_oe
);
  op_e               op;
  logic              acc, wr_en, cs_fall;
  logic              mem_we, mem_all;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;

  assign op        = op_e'(req_op);
  assign req_ready = !busy;
  assign acc       = req_valid && req_ready;

  eeprog_latch u_latch (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .set_i(acc && (op == OP_WREN)),
    .clr_i(acc && (op == OP_WRDIS)),
    .en_o(wr_en)
  );

  eeprog_status #(.CSL_MIN(CSL_MIN_CYC)) u_status (
    .clk(clk), .rst_n(rst_n), .cs(cs), .busy(busy),
    .cs_fall(cs_fall), .dout(dout), .dout_oe(dout_oe)
  );

  eeprog_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_WORD(T_WORD_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .wr_ok(wr_en),
    .acc(acc), .op(op), .addr(req_addr), .data(req_data), .cs_fall(cs_fall),
    .busy(busy), .mem_we(mem_we), .mem_all(mem_all),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  eeprog_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .all(mem_all),
    .waddr(mem_addr), .wdata(mem_wdata), .raddr(rd_addr), .rdata(rd_data)
  );
endmodule

// File: rtl/eeprog_engine_chk.sv
module eeprog_engine_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_good,
  input logic              cs,
  input logic              req_ready,
  input logic              busy,
  input logic              dout_oe,
  input logic              wr_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data
);
  assert_ready_low_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_oe_needs_cs_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> cs);

  assert_oe_opens_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> $past(busy));

  assert_start_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!cs));

  assert_start_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  assert_pg_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !busy);

  assert_pg_clears_latch_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !wr_en);

  assert_mem_quiet_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(rd_addr)) |-> $stable(rd_data));
endmodule

bind eeprog_engine eeprog_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs(cs),
  .req_ready(req_ready), .busy(busy), .dout_oe(dout_oe),
  .wr_en(wr_en), .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/tb_eeprog_engine.sv
`timescale 1ns/1ps
module tb_eeprog_engine;
  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int TW  = 16;
  localparam int CSL = 4;
  localparam logic [2:0] C_WREN = 3'd1, C_WRDIS = 3'd2, C_ERASE = 3'd3,
                         C_WRITE = 3'd4, C_ERALL = 3'd5, C_WRALL = 3'd6;

  logic          clk = 1'b0, rst_n = 1'b0, pwr_good = 1'b1, cs = 1'b0;
  logic          req_valid = 1'b0;
  logic [2:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0, rd_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          req_ready, busy, dout, dout_oe;
  logic [DW-1:0] rd_data;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  eeprog_engine #(.ADDR_W(AW), .DATA_W(DW), .T_WORD_CYC(TW), .CSL_MIN_CYC(CSL)) dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cs(cs),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .dout(dout), .dout_oe(dout_oe)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic mem_is(string tag, logic [AW-1:0] a, logic [DW-1:0] exp);
    rd_addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic send(logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Raise cs, deliver the request, drop cs; cs falls at the final negedge.
  task automatic launch(logic [2:0] op, logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); cs = 1'b1;
    send(op, a, d);
    cs = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic all_are(string tag, logic [DW-1:0] exp);
    int bad = 0;
    for (int i = 0; i < (1 << AW); i++) begin
      rd_addr = AW'(i); #1;
      if (rd_data !== exp) bad++;
    end
    chk(tag, bad, 0);
  endtask

  task automatic t_reset_R1;
    chk("R1 busy", busy, 0);
    chk("R1 ready", req_ready, 1);
    chk("R1 dout_oe", dout_oe, 0);
    all_are("R1 array zero", 8'h00);
  endtask

  task automatic t_locked_R2;
    launch(C_WRITE, 4'd3, 8'hA5);
    @(negedge clk);
    chk("R2 locked no start", busy, 0);
    repeat (20) @(negedge clk);
    chk("R2 locked still idle", busy, 0);
    mem_is("R2 locked word kept", 4'd3, 8'h00);
  endtask

  task automatic t_erase_R3_R4;
    int n; logic [DW-1:0] prev;
    send(C_WREN, '0, '0);
    @(negedge clk); cs = 1'b1;
    send(C_ERASE, 4'd2, '0);
    repeat (10) @(negedge clk);
    chk("R3 no start while cs high", busy, 0);
    cs = 1'b0;
    @(negedge clk);
    chk("R3 start after fall", busy, 1);
    rd_addr = 4'd2; n = 0; prev = '0;
    while (busy && n < 1000) begin #1 prev = rd_data; n++; @(negedge clk); end
    chk("R4 erase duration", n, TW);
    chk("R8 old value in last busy cycle", prev, 8'h00);
    mem_is("R4 R8 erased word", 4'd2, 8'hFF);
  endtask

  task automatic t_write_R5;
    int n; logic [DW-1:0] early, late;
    rd_addr = 4'd4;
    launch(C_WRITE, 4'd4, 8'h5A);
    @(negedge clk);
    n = 0; early = 'x; late = 'x;
    while (busy && n < 1000) begin
      n++; #1;
      if (n == 3)  early = rd_data;
      if (n == 12) late  = rd_data;
      @(negedge clk);
    end
    chk("R5 first half old", early, 8'h00);
    chk("R5 second half erased", late, 8'hFF);
    chk("R5 duration", n, TW);
    mem_is("R5 final data", 4'd4, 8'h5A);
  endtask

  task automatic t_wrall_R7;
    int n; logic [DW-1:0] early, late;
    rd_addr = 4'd4;
    launch(C_WRALL, '0, 8'h3C);
    @(negedge clk);
    n = 0; early = 'x; late = 'x;
    while (busy && n < 1000) begin
      n++; #1;
      if (n == 10) early = rd_data;
      if (n == 40) late  = rd_data;
      @(negedge clk);
    end
    chk("R7 first half old", early, 8'h5A);
    chk("R7 second half erased", late, 8'hFF);
    chk("R7 duration", n, 4 * TW);
    all_are("R7 all words written", 8'h3C);
  endtask

  task automatic t_erall_R6;
    int n;
    launch(C_ERALL, '0, '0);
    @(negedge clk);
    wait_idle(n);
    chk("R6 duration", n, 2 * TW);
    all_are("R6 all ones", 8'hFF);
  endtask

  task automatic t_status_R10;
    int n;
    launch(C_WRITE, 4'd6, 8'h11);
    repeat (CSL) @(negedge clk);
    cs = 1'b1;
    @(negedge clk);
    chk("R10 oe after qualified rise", dout_oe, 1);
    chk("R10 shows busy", dout, 0);
    wait_idle(n);
    chk("R10 oe held when done", dout_oe, 1);
    chk("R10 shows ready", dout, 1);
    mem_is("R10 word written", 4'd6, 8'h11);
    cs = 1'b0; #1;
    chk("R10 oe off on cs low", dout_oe, 0);
  endtask

  task automatic t_short_R11;
    int n;
    launch(C_WRITE, 4'd7, 8'h22);
    repeat (CSL - 1) @(negedge clk);
    cs = 1'b1;
    repeat (2) @(negedge clk);
    chk("R11 short low no status", dout_oe, 0);
    chk("R11 cycle still running", busy, 1);
    wait_idle(n);
    cs = 1'b0;
  endtask

  task automatic t_held_R11;
    int n;
    launch(C_WRITE, 4'd8, 8'h33);
    @(negedge clk);
    wait_idle(n);
    cs = 1'b1;
    @(negedge clk);
    chk("R11 held low no status", dout_oe, 0);
    mem_is("R11 held write done", 4'd8, 8'h33);
    @(negedge clk); cs = 1'b0;
  endtask

  task automatic t_busy_R9;
    int n;
    launch(C_WRITE, 4'd9, 8'h77);
    @(negedge clk);
    chk("R9 ready low while busy", req_ready, 0);
    req_valid = 1'b1; req_op = C_WRDIS;
    @(negedge clk);
    req_op = C_WRITE; req_addr = 4'd10; req_data = 8'h55;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle(n);
    mem_is("R9 running write unaffected", 4'd9, 8'h77);
    @(negedge clk); cs = 1'b1;
    @(negedge clk); cs = 1'b0;
    @(negedge clk);
    chk("R9 dropped request not armed", busy, 0);
    mem_is("R9 dropped write no effect", 4'd10, 8'hFF);
    launch(C_WRITE, 4'd10, 8'h99);
    @(negedge clk);
    chk("R9 dropped disable ignored", busy, 1);
    wait_idle(n);
    mem_is("R9 later write", 4'd10, 8'h99);
  endtask

  task automatic t_power_R12;
    int n;
    launch(C_WRALL, '0, 8'hE1);
    repeat (6) @(negedge clk);
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R12 abort", busy, 0);
    mem_is("R12 no update after abort", 4'd9, 8'h77);
    send(C_WREN, '0, '0);
    pwr_good = 1'b1;
    launch(C_ERASE, 4'd9, '0);
    @(negedge clk);
    chk("R12 latch cleared and enable blocked", busy, 0);
    repeat (4) @(negedge clk);
    mem_is("R12 word kept", 4'd9, 8'h77);
    send(C_WREN, '0, '0);
    launch(C_ERASE, 4'd9, '0);
    @(negedge clk);
    chk("R12 re-enabled start", busy, 1);
    wait_idle(n);
    mem_is("R12 erase after re-enable", 4'd9, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_R1();
    t_locked_R2();
    t_erase_R3_R4();
    t_write_R5();
    t_wrall_R7();
    t_erall_R6();
    t_status_R10();
    t_short_R11();
    t_held_R11();
    t_busy_R9();
    t_power_R12();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule